// File: doc/BRIEF.md
# Sleep Entry Sequencer

This block chooses when the system leaves the working state (S0) for one of the sleep states S1, S3, S4 or S5, and walks it through that entry. Software takes the graceful route: it writes a sleep-type code together with a sleep-enable request. The sequencer then asks the processor to stop its clock. It waits for the stop-grant acknowledge, drives the target state and drops the enable bit on its own.

Two ungraceful routes force S5 without waiting for the processor. The first is a power button held for a full override interval, counted on ticks of the always-on real-time clock. The second is a thermal trip seen while the system is in S0 or S1.

The same block also settles contention. While a sleep request is pending, or the system is not in S0, thermal throttling is disabled. A processor C-state request is granted only when no sleep entry is under way.

The FSM has three states. `SQ_IDLE` is S0 with nothing pending. `SQ_STOPCLK` means the stop-clock request is out and the block waits for the acknowledge. `SQ_ASLEEP` means `sleep_state` shows the target.

The transitions are:
- IDLE→STOPCLK when the enable bit is set.
- STOPCLK→ASLEEP on the acknowledge, using the software target.
- IDLE→ASLEEP and STOPCLK→ASLEEP on a thermal trip or a button override, with target S5.
- ASLEEP→ASLEEP with the target raised to S5 on an override, or on a thermal trip while the target is S1.

Only reset leaves ASLEEP.

Top module: `sleep_entry_seq`

## Requirements
- R1: While reset is asserted and right after it, `sleep_state` is 0 (S0), and `slp_en`, `stop_clk_req`, `throttle_dis` and `cstate_grant` are 0.
- R2: A one-cycle `sw_wr` pulse in SQ_IDLE with `sw_typ` of 1, 3, 4 or 5 sets `slp_en` at that edge. The codes 0, 2, 6 and 7 are reserved: `slp_en` stays 0 and the block stays in S0.
- R3: Starting the cycle after `slp_en` is set, `stop_clk_req` is 1 and stays 1 until `stop_grant_ack` is seen. At that edge `stop_clk_req` drops, `sleep_state` takes the written type, and `slp_en` clears.
- R4: Holding `pwr_button` for OVR_TICKS `rtc_tick` strobes makes `sleep_state` 5 one edge after the count is reached. This happens without `stop_grant_ack`, from S0, from the stop-clock wait, or from any sleep state.
- R5: Releasing `pwr_button` clears the override count, so a later press must collect the full OVR_TICKS again.
- R6: `therm_trip` in S0 (idle or stop-clock wait) or in S1 gives `sleep_state` 5 at the next edge. In S3 or S4 it has no effect.
- R7: `throttle_dis` is 1 exactly when `slp_en` is 1 or the block is not in SQ_IDLE.
- R8: `cstate_grant` equals `cstate_req` only in SQ_IDLE with `slp_en` 0; otherwise it is 0.
- R9: A `sw_wr` outside SQ_IDLE is ignored: `slp_en` and `sleep_state` are unchanged.
- R10: S5 holds until reset, and `sleep_state` never takes the values 2, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on clock |
| rst_n | input | 1 | asynchronous reset, active low |
| rtc_tick | input | 1 | one-cycle strobe per real-time-clock period (32.768 kHz), already synchronised |
| sw_wr | input | 1 | software write of the sleep-enable request |
| sw_typ | input | 3 | sleep type written with `sw_wr` |
| pwr_button | input | 1 | power button, 1 = pressed |
| therm_trip | input | 1 | catastrophic thermal trip |
| cstate_req | input | 1 | processor asks to enter a C-state |
| stop_grant_ack | input | 1 | processor has stopped its clock |
| slp_en | output | 1 | sleep-enable request pending |
| sleep_state | output | 3 | 0 = S0, otherwise the sleep state number |
| stop_clk_req | output | 1 | request to the processor to stop its clock |
| throttle_dis | output | 1 | thermal throttling disabled |
| cstate_grant | output | 1 | C-state entry allowed |

## Verification
The bench aims at the overrides that arrive mid-sequence. One case is a button or thermal event during the stop-clock wait; a design that insists on the acknowledge would hang there. Another is a thermal trip in S3; a design that forgets the S0/S1 limit would jump to S5. A button released one tick short and pressed again exposes a counter that is not cleared on release, because it would override early. Reserved sleep codes, and writes made while asleep or waiting, catch a decoder that latches anything. A C-state request held across a sleep write shows a grant that is not withdrawn.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_STOPCLK = 2'd1,
        SQ_ASLEEP  = 2'd2
    } seq_state_t;

    localparam logic [2:0] SS_S0 = 3'd0;
    localparam logic [2:0] SS_S1 = 3'd1;
    localparam logic [2:0] SS_S3 = 3'd3;
    localparam logic [2:0] SS_S4 = 3'd4;
    localparam logic [2:0] SS_S5 = 3'd5;

    // R2: only S1, S3, S4 and S5 are legal software targets
    function automatic logic typ_is_legal(input logic [2:0] t);
        return (t == SS_S1) || (t == SS_S3) || (t == SS_S4) || (t == SS_S5);
    endfunction

endpackage

// File: rtl/sleep_ovr_timer.sv
module sleep_ovr_timer #(
    parameter int OVR_TICKS = 131072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rtc_tick,
    input  logic button,
    output logic ovr_hit
);
    localparam int CW = $clog2(OVR_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(OVR_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!button) begin
            cnt <= '0;
        end else if (rtc_tick && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ovr_hit = (cnt == LIMIT);

    // R5: a release always empties the count
    a_r5_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !button |=> (cnt == '0));
    // R4: count advances only on an RTC strobe
    a_r4_rtc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_tick && button) |=> $stable(cnt));

endmodule

// File: rtl/sleep_req_latch.sv
module sleep_req_latch
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_wr,
    input  logic [2:0] sw_typ,
    input  logic       idle,
    input  logic       done,
    output logic       slp_en,
    output logic [2:0] typ_q
);
    logic accept;

    assign accept = sw_wr && idle && typ_is_legal(sw_typ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slp_en <= 1'b0;
            typ_q  <= SS_S0;
        end else if (done) begin
            slp_en <= 1'b0;
        end else if (accept && !slp_en) begin
            slp_en <= 1'b1;
            typ_q  <= sw_typ;
        end
    end

    // R9: no request can appear while not idle
    a_r9_no_set_outside_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !slp_en) |=> !slp_en);
    // R2: reserved codes never arm the request
    a_r2_reserved_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (!slp_en && sw_wr && !typ_is_legal(sw_typ)) |=> !slp_en);

endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
    import sleep_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slp_en,
    input  logic [2:0] typ_q,
    input  logic       ovr_hit,
    input  logic       therm_trip,
    input  logic       ack,
    output logic       idle,
    output logic       done,
    output logic       stop_clk_req,
    output logic [2:0] sleep_state
);
    seq_state_t st, st_nxt;
    logic [2:0] tgt, tgt_nxt;
    logic       force_s5;

    assign force_s5 = ovr_hit || therm_trip;

    always_comb begin
        st_nxt  = st;
        tgt_nxt = tgt;
        unique case (st)
            SQ_IDLE: begin
                if (force_s5) begin
                    st_nxt  = SQ_ASLEEP;
                    tgt_nxt = SS_S5;
                end else if (slp_en) begin
                    st_nxt = SQ_STOPCLK;
                end
            end
            SQ_STOPCLK: begin
                if (force_s5) begin
                    st_nxt  = SQ_ASLEEP;
                    tgt_nxt = SS_S5;
                end else if (ack) begin
                    st_nxt  = SQ_ASLEEP;
                    tgt_nxt = typ_q;
                end
            end
            SQ_ASLEEP: begin
                if (ovr_hit || (therm_trip && tgt == SS_S1)) begin
                    tgt_nxt = SS_S5;
                end
            end
            default: begin
                st_nxt  = SQ_IDLE;
                tgt_nxt = SS_S0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            tgt <= SS_S0;
        end else begin
            st  <= st_nxt;
            tgt <= tgt_nxt;
        end
    end

    always_comb begin
        idle         = (st == SQ_IDLE);
        stop_clk_req = (st == SQ_STOPCLK);
        sleep_state  = (st == SQ_ASLEEP) ? tgt : SS_S0;
        done         = (st != SQ_ASLEEP) && (st_nxt == SQ_ASLEEP);
    end

    // R6: thermal trip in S0 lands in S5 at the next edge
    a_r6_trip_from_s0: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_trip && st != SQ_ASLEEP) |=> (sleep_state == SS_S5));
    // R10: S5 is terminal until reset
    a_r10_s5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state == SS_S5) |=> (sleep_state == SS_S5));
    // R3: stop-clock wait is held until an acknowledge or override
    a_r3_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_clk_req && !ack && !force_s5) |=> stop_clk_req);

endmodule

// File: rtl/sleep_entry_seq.sv
module sleep_entry_seq
    import sleep_seq_pkg::*;
#(
    parameter int OVR_TICKS = 131072
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rtc_tick,
    input  logic       sw_wr,
    input  logic [2:0] sw_typ,
    input  logic       pwr_button,
    input  logic       therm_trip,
    input  logic       cstate_req,
    input  logic       stop_grant_ack,
    output logic       slp_en,
    output logic [2:0] sleep_state,
    output logic       stop_clk_req,
    output logic       throttle_dis,
    output logic       cstate_grant
);
    logic       ovr_hit;
    logic       idle;
    logic       done;
    logic [2:0] typ_q;

    sleep_ovr_timer #(.OVR_TICKS(OVR_TICKS)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rtc_tick (rtc_tick),
        .button   (pwr_button),
        .ovr_hit  (ovr_hit)
    );

    sleep_req_latch u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_wr  (sw_wr),
        .sw_typ (sw_typ),
        .idle   (idle),
        .done   (done),
        .slp_en (slp_en),
        .typ_q  (typ_q)
    );

    sleep_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slp_en       (slp_en),
        .typ_q        (typ_q),
        .ovr_hit      (ovr_hit),
        .therm_trip   (therm_trip),
        .ack          (stop_grant_ack),
        .idle         (idle),
        .done         (done),
        .stop_clk_req (stop_clk_req),
        .sleep_state  (sleep_state)
    );

    assign throttle_dis = slp_en || !idle;
    assign cstate_grant = cstate_req && idle && !slp_en;

    // R8: a C-state grant never overlaps any part of sleep entry
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cstate_grant |-> (sleep_state == SS_S0 && !stop_clk_req && !slp_en));
    // R3: leaving the stop-clock wait clears the software request
    a_r3_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_clk_req) |-> !slp_en);
    // R7: a pending request always blocks throttling
    a_r7_throttle_block: assert property (@(posedge clk) disable iff (!rst_n)
        (slp_en || sleep_state != SS_S0) |-> throttle_dis);
    // R10: unused codes never appear
    a_r10_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_state != 3'd2 && sleep_state != 3'd6 && sleep_state != 3'd7));

endmodule

// File: tb/test_sleep_entry_seq.sv
module test_sleep_entry_seq;
    localparam int OT = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       rtc_tick = 1'b0;
    logic       sw_wr = 1'b0;
    logic [2:0] sw_typ = 3'd0;
    logic       pwr_button = 1'b0;
    logic       therm_trip = 1'b0;
    logic       cstate_req = 1'b0;
    logic       stop_grant_ack = 1'b0;
    logic       slp_en;
    logic [2:0] sleep_state;
    logic       stop_clk_req;
    logic       throttle_dis;
    logic       cstate_grant;

    sleep_entry_seq #(.OVR_TICKS(OT)) i_sleep_entry_seq (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .sw_wr(sw_wr),
        .sw_typ(sw_typ), .pwr_button(pwr_button), .therm_trip(therm_trip),
        .cstate_req(cstate_req), .stop_grant_ack(stop_grant_ack),
        .slp_en(slp_en), .sleep_state(sleep_state), .stop_clk_req(stop_clk_req),
        .throttle_dis(throttle_dis), .cstate_grant(cstate_grant)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit armed = 0;
    string cur_req = "R1";

    // behavioural reference: 0 idle, 1 waiting for grant, 2 asleep
    int m_st = 0, m_tgt = 0, m_typ = 0, m_cnt = 0;
    bit m_slp = 0;

    function automatic bit legal(int t);
        return (t == 1) || (t == 3) || (t == 4) || (t == 5);
    endfunction

    always @(posedge clk) begin
        int st0;
        bit hit, fin;
        if (!rst_n) begin
            m_st = 0; m_tgt = 0; m_typ = 0; m_cnt = 0; m_slp = 0;
        end else begin
            st0 = m_st;
            hit = (m_cnt == OT);
            fin = 0;
            if (st0 == 2) begin
                if (hit || (therm_trip && m_tgt == 1)) m_tgt = 5;
            end else if (hit || therm_trip) begin
                m_st = 2; m_tgt = 5; fin = 1;
            end else if (st0 == 1 && stop_grant_ack) begin
                m_st = 2; m_tgt = m_typ; fin = 1;
            end else if (st0 == 0 && m_slp) begin
                m_st = 1;
            end
            if (fin) m_slp = 0;
            else if (!m_slp && sw_wr && st0 == 0 && legal(int'(sw_typ))) begin
                m_slp = 1; m_typ = int'(sw_typ);
            end
            if (!pwr_button) m_cnt = 0;
            else if (rtc_tick && m_cnt != OT) m_cnt = m_cnt + 1;
        end
        #5 if (armed) compare();
    end

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cur_req, "sleep_state", int'(sleep_state), (m_st == 2) ? m_tgt : 0);
        chk(cur_req, "slp_en", int'(slp_en), int'(m_slp));
        chk("R3", "stop_clk_req", int'(stop_clk_req), int'(m_st == 1));
        chk("R7", "throttle_dis", int'(throttle_dis), int'(m_slp || m_st != 0));
        chk("R8", "cstate_grant", int'(cstate_grant), int'(cstate_req && m_st == 0 && !m_slp));
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sw_wr = 0; pwr_button = 0; therm_trip = 0; cstate_req = 0; stop_grant_ack = 0;
        cyc(2);
        armed = 1;
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic write_typ(int t);
        sw_typ = 3'(t); sw_wr = 1'b1;
        cyc(1);
        sw_wr = 1'b0;
    endtask

    initial begin
        forever begin
            cyc(2);
            rtc_tick = 1'b1;
            cyc(1);
            rtc_tick = 1'b0;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_bad++;
                $display("FAIL watchdog expired");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        cur_req = "R1";
        do_reset();
        cyc(3);
        // R2: reserved codes rejected
        cur_req = "R2";
        cstate_req = 1;
        write_typ(0); cyc(2);
        write_typ(2); cyc(2);
        write_typ(6); cyc(2);
        write_typ(7); cyc(3);
        // R3 graceful entry to S3 while C-state requested (R8)
        cur_req = "R3";
        write_typ(3); cyc(5);
        stop_grant_ack = 1; cyc(1); stop_grant_ack = 0;
        cyc(3);
        // R6 trip ignored in S3, R9 write ignored asleep
        cur_req = "R6";
        therm_trip = 1; cyc(3); therm_trip = 0;
        cur_req = "R9";
        write_typ(1); cyc(3);
        // R4 override from S3
        cur_req = "R4";
        pwr_button = 1; cyc(40); pwr_button = 0;
        cur_req = "R10";
        cyc(5);
        // S1 then thermal trip
        cur_req = "R6";
        do_reset();
        cstate_req = 0;
        write_typ(1); cyc(2);
        cur_req = "R9";
        write_typ(4); cyc(2);
        cur_req = "R6";
        stop_grant_ack = 1; cyc(1); stop_grant_ack = 0; cyc(3);
        therm_trip = 1; cyc(1); therm_trip = 0; cyc(4);
        // thermal trip from idle S0
        do_reset();
        therm_trip = 1; cyc(1); therm_trip = 0; cyc(4);
        // R5: partial hold, release, full hold
        cur_req = "R5";
        do_reset();
        pwr_button = 1; cyc(19); pwr_button = 0; cyc(2);
        pwr_button = 1; cyc(20); cyc(12); pwr_button = 0; cyc(3);
        // R4 override during stop-clock wait
        cur_req = "R4";
        do_reset();
        write_typ(4); cyc(1);
        pwr_button = 1; cyc(40); pwr_button = 0; cyc(3);
        // graceful S4 and S5
        cur_req = "R3";
        do_reset();
        write_typ(4); cyc(2);
        stop_grant_ack = 1; cyc(1); stop_grant_ack = 0; cyc(3);
        do_reset();
        write_typ(5); stop_grant_ack = 1; cyc(3); stop_grant_ack = 0; cyc(3);
        cur_req = "R1";
        do_reset();
        cyc(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule